// File: doc/BRIEF.md
# SMBus Control Register Slave

This block is a two-wire serial slave that holds a small bank of eight 8-bit control registers for a clock-generation subsystem. A bus master reaches the registers with four transaction types: single-byte write, single-byte read, block write and block read. The first byte after the slave address is a command byte. Its most significant bit picks between a single indexed access and a sequential block access that always begins at offset 0.

SCL and SDA are sampled on the system clock through two-stage synchronisers. Edges and bus conditions are detected on the synchronised copies. SDA is open-drain: the block never drives it high and only asserts a pull-low enable. The register contents are always visible on a flat output port. Three strap bits enter as read-only inputs and appear inside register 6.

Top module: `smbus_ctl_regs`

## Requirements
- R1: The slave acknowledges a first byte of 0xD2 (7-bit address 0x69, write) or 0xD3 (read). Any other address gets no acknowledge, and the slave ignores the bus until the next START.
- R2: A command byte with bit 7 = 1 selects a single-byte access, and bits 6:0 give the register offset. In a write, the byte that follows goes to that offset. All bytes travel most significant bit first.
- R3: For a single-byte read, the master sends address-write and command, then a repeated START and address-read. The slave then returns the register at the commanded offset.
- R4: A command byte with bit 7 = 0 selects a block write. The next byte is a count, which is acknowledged but not used to limit the transfer. Each later data byte is stored at offsets 0, 1, 2 and upward, and every byte is acknowledged. A STOP after any whole byte leaves the higher registers unchanged.
- R5: A block read uses the same command and a repeated START with address-read. The slave sends the count value 0x08 first, then registers from offset 0 upward, until the master withholds its acknowledge.
- R6: After reset the registers hold these values: offset 0 = 0xFF, 1 = 0xF6, 2 = 0xFF, 3 = 0x00, 4 = 0x07, 5 = 0x00, 6 = 0x18 with bits 2:0 taken from the strap input. `ctl_o` carries offset k in bits 8k+7:8k.
- R7: Offset 7 always reads 0x28 (revision 2 in bits 7:4, vendor code 8 in bits 3:0). Writes to it have no effect.
- R8: Bits 2:0 of offset 6 always mirror `strap_i`. Writes change only bits 7:3 of that register.
- R9: Writes to offsets above 7 are discarded, and reads from them return 0x00.
- R10: A START that comes after the second SCL rise of a byte, or a STOP at any time, ends the transfer. The slave releases SDA, returns to idle and writes nothing from the cut-off byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| strap_i | input | STRAP_W (3) | Read-only strap bits shown in offset 6 |
| ctl_o | output | 64 | All eight registers, offset k in bits 8k+7:8k |

## Verification
The checks assume that every SCL phase lasts several system clocks longer than the synchroniser delay. Under that assumption, the slave's SDA changes and register updates always land while the raw SCL is still low. They also assume that SDA moves only while SCL is low, except at intended START and STOP conditions. The bench holds each quarter-bit for eight system clocks. It changes its own SDA only with SCL low, except inside its START and STOP routines and the single deliberate mid-byte START used for the abort case.

// File: rtl/smbus_ctl_regs.sv
module smbus_ctl_regs #(
  parameter logic [6:0]  DEV_ADDR  = 7'h69,
  parameter logic [7:0]  ID_VALUE  = 8'h28,
  parameter logic [7:0]  BLK_COUNT = 8'd8,
  parameter int          STRAP_W   = 3,
  parameter logic [55:0] RST_IMAGE = 56'h18_00_07_00_FF_F6_FF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [63:0]        ctl_o
);
  localparam int NFULL = 6;
  localparam int PW    = 7;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_CNT, S_WR, S_RD, S_SKIP} st_t;

  st_t                st;
  logic [2:0]         scl_q, sda_q;
  logic [3:0]         bcnt;
  logic [7:0]         sh, tx;
  logic [PW-1:0]      ptr;
  logic               rw, cnt_pend, mack;
  logic [8*NFULL-1:0] rwb;
  logic [7:STRAP_W]   r6hi;

  logic scl_rise, scl_fall, start_c, stop_c, active, load_rd;
  logic [7:0] tx_next;

  assign scl_rise = scl_q[1] & ~scl_q[2];
  assign scl_fall = ~scl_q[1] & scl_q[2];
  assign start_c  = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  assign stop_c   = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
  assign active   = (st != S_IDLE) && (st != S_SKIP);
  assign load_rd  = (st == S_ADDR && rw) || (st == S_RD && mack);

  assign ctl_o   = {ID_VALUE, r6hi, strap_i, rwb};
  assign tx_next = cnt_pend ? BLK_COUNT :
                   (ptr < 7'd8) ? ctl_o[{ptr[2:0], 3'b000} +: 8] : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q    <= 3'b111;
      sda_q    <= 3'b111;
      st       <= S_IDLE;
      bcnt     <= '0;
      sh       <= '0;
      tx       <= '0;
      ptr      <= '0;
      rw       <= 1'b0;
      cnt_pend <= 1'b0;
      mack     <= 1'b0;
      sda_oe   <= 1'b0;
      rwb      <= RST_IMAGE[8*NFULL-1:0];
      r6hi     <= RST_IMAGE[55:48+STRAP_W];
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
      if (start_c) begin
        sda_oe <= 1'b0;
        bcnt   <= '0;
        st     <= (bcnt <= 4'd1) ? S_ADDR : S_IDLE;
      end else if (stop_c) begin
        sda_oe <= 1'b0;
        bcnt   <= '0;
        st     <= S_IDLE;
      end else if (active) begin
        if (scl_rise) begin
          if (bcnt < 4'd8) sh <= {sh[6:0], sda_q[1]};
          if (bcnt == 4'd8) mack <= ~sda_q[1];
          if (bcnt < 4'd9) bcnt <= bcnt + 4'd1;
        end else if (scl_fall) begin
          if (bcnt == 4'd8) begin
            case (st)
              S_ADDR: begin
                if (sh[7:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1;
                  rw     <= sh[0];
                end else begin
                  st   <= S_SKIP;
                  bcnt <= '0;
                end
              end
              S_CMD: begin
                sda_oe   <= 1'b1;
                cnt_pend <= ~sh[7];
                ptr      <= sh[7] ? sh[6:0] : '0;
                st       <= sh[7] ? S_WR : S_CNT;
              end
              S_CNT: begin
                sda_oe <= 1'b1;
                st     <= S_WR;
              end
              S_WR: begin
                sda_oe <= 1'b1;
                if (ptr < 7'(NFULL)) rwb[{ptr[2:0], 3'b000} +: 8] <= sh;
                else if (ptr == 7'(NFULL)) r6hi <= sh[7:STRAP_W];
                if (ptr != '1) ptr <= ptr + 7'd1;
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (bcnt == 4'd9) begin
            bcnt <= '0;
            if (load_rd) begin
              tx     <= tx_next;
              sda_oe <= ~tx_next[7];
              st     <= S_RD;
              if (cnt_pend) cnt_pend <= 1'b0;
              else if (ptr != '1) ptr <= ptr + 7'd1;
            end else begin
              sda_oe <= 1'b0;
              if (st == S_ADDR) st <= S_CMD;
              else if (st == S_RD) st <= S_SKIP;
            end
          end else if (st == S_RD && bcnt != 4'd0) begin
            tx     <= {tx[6:0], 1'b0};
            sda_oe <= ~tx[6];
          end
        end
      end
    end
  end
endmodule

// File: rtl/smbus_ctl_regs_chk.sv
module smbus_ctl_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_i,
  input logic        sda_oe,
  input logic [63:0] ctl_o,
  input logic [2:0]  st_i,
  input logic [3:0]  bcnt_i
);
  // R1
  oe_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  // R2
  write_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ctl_o[47:0]) || !$stable(ctl_o[55:51])) |-> !scl_i);

  // R6
  reset_image_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ctl_o[47:0] == 48'h00_07_00_FF_F6_FF && ctl_o[55:51] == 5'b00011));

  // R10
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_i == 3'd0) |-> !sda_oe);

  // R4
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt_i <= 4'd9);
endmodule

bind smbus_ctl_regs smbus_ctl_regs_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .ctl_o(ctl_o), .st_i(st), .bcnt_i(bcnt)
);

// File: tb/smbus_ctl_regs_tb.sv
module smbus_ctl_regs_tb_top;
  localparam int Q = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic sda_oe;
  logic [63:0] ctl_o;
  logic sda_w;
  int checks = 0, errors = 0;

  assign sda_w = sda_m & ~sda_oe;
  always #10 clk = ~clk;

  smbus_ctl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_w),
    .sda_oe(sda_oe), .strap_i(strap), .ctl_o(ctl_o)
  );

  // {offset, write data, expected read}
  localparam logic [23:0] VEC [8] = '{
    {8'h00, 8'h5A, 8'h5A}, {8'h03, 8'hA5, 8'hA5}, {8'h05, 8'h3C, 8'h3C},
    {8'h06, 8'hFF, 8'hFD}, {8'h07, 8'h00, 8'h28}, {8'h09, 8'h77, 8'h00},
    {8'h01, 8'h81, 8'h81}, {8'h04, 8'h0F, 8'h0F}
  };
  localparam logic [7:0] BLK_EXP [10] = '{
    8'h08, 8'h11, 8'h22, 8'h33, 8'hA5, 8'h0F, 8'h3C, 8'hFD, 8'h28, 8'h00
  };

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wq;
    repeat (Q) @(posedge clk);
    #3;
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wq; scl_m = 1'b1; wq; sda_m = 1'b0; wq; scl_m = 1'b0; wq;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq; scl_m = 1'b1; wq; sda_m = 1'b1; wq;
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq; scl_m = 1'b1; wq; scl_m = 1'b0;
    end
    sda_m = 1'b1; wq; scl_m = 1'b1; wq; ack = ~sda_w; scl_m = 1'b0; wq;
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq; scl_m = 1'b1; wq; b[i] = sda_w; scl_m = 1'b0;
    end
    sda_m = ~give_ack; wq; scl_m = 1'b1; wq; scl_m = 1'b0; wq; sda_m = 1'b1;
  endtask

  task automatic byte_wr(input logic [7:0] off, input logic [7:0] d, output logic all_ack);
    logic a0, a1, a2;
    bus_start;
    put_byte(8'hD2, a0);
    put_byte({1'b1, off[6:0]}, a1);
    put_byte(d, a2);
    bus_stop;
    all_ack = a0 & a1 & a2;
  endtask

  task automatic byte_rd(input logic [7:0] off, output logic [7:0] d);
    logic a;
    bus_start;
    put_byte(8'hD2, a);
    put_byte({1'b1, off[6:0]}, a);
    bus_start;
    put_byte(8'hD3, a);
    get_byte(1'b0, d);
    bus_stop;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic ok;
    logic [7:0] rd;
    string tag;
    repeat (5) @(posedge clk);
    #3 rst_n = 1'b1;
    @(posedge clk); #3;
    chk("R6 reset image", ctl_o, 64'h28_1D_00_07_00_FF_F6_FF);
    chk("R6 sda released", {63'd0, sda_oe}, 64'd0);

    for (int v = 0; v < 8; v++) begin
      tag = (VEC[v][23:16] == 8'h07) ? "R7" : (VEC[v][23:16] == 8'h06) ? "R8" :
            (VEC[v][23:16] > 8'h07) ? "R9" : "R2";
      byte_wr(VEC[v][23:16], VEC[v][15:8], ok);
      chk({"R1 ack ", tag}, {63'd0, ok}, 64'd1);
      byte_rd(VEC[v][23:16], rd);
      chk({"R3 read ", tag}, {56'd0, rd}, {56'd0, VEC[v][7:0]});
    end
    chk("R9 R7 image after table", ctl_o, 64'h28_FD_3C_0F_A5_FF_81_5A);

    bus_start;
    put_byte(8'hD2, ok); chk("R4 addr ack", {63'd0, ok}, 64'd1);
    put_byte(8'h00, ok); chk("R4 cmd ack", {63'd0, ok}, 64'd1);
    put_byte(8'h03, ok); chk("R4 count ack", {63'd0, ok}, 64'd1);
    put_byte(8'h11, ok); chk("R4 d0 ack", {63'd0, ok}, 64'd1);
    put_byte(8'h22, ok); chk("R4 d1 ack", {63'd0, ok}, 64'd1);
    put_byte(8'h33, ok); chk("R4 d2 ack", {63'd0, ok}, 64'd1);
    bus_stop;
    chk("R4 block write", {40'd0, ctl_o[23:0]}, {40'd0, 24'h33_22_11});
    chk("R4 rest untouched", {56'd0, ctl_o[31:24]}, {56'd0, 8'hA5});

    bus_start;
    put_byte(8'hD2, ok);
    put_byte(8'h00, ok);
    bus_start;
    put_byte(8'hD3, ok); chk("R5 read addr ack", {63'd0, ok}, 64'd1);
    for (int k = 0; k < 10; k++) begin
      get_byte(k != 9, rd);
      chk((k == 9) ? "R9 block past end" : "R5 block read", {56'd0, rd}, {56'd0, BLK_EXP[k]});
    end
    bus_stop;

    bus_start;
    put_byte(8'hA4, ok); chk("R1 foreign addr nack", {63'd0, ok}, 64'd0);
    put_byte(8'h83, ok); chk("R1 ignored cmd", {63'd0, ok}, 64'd0);
    put_byte(8'h55, ok);
    bus_stop;
    chk("R1 no write", {56'd0, ctl_o[31:24]}, {56'd0, 8'hA5});

    strap = 3'b010;
    wq;
    byte_rd(8'h06, rd);
    chk("R8 strap read", {56'd0, rd}, {56'd0, 8'hFA});
    chk("R8 strap port", {56'd0, ctl_o[55:48]}, {56'd0, 8'hFA});

    bus_start;
    put_byte(8'hD2, ok);
    put_byte(8'h82, ok);
    for (int i = 0; i < 4; i++) begin
      sda_m = 1'b0; wq; scl_m = 1'b1; wq; scl_m = 1'b0;
    end
    sda_m = 1'b1; wq; scl_m = 1'b1; wq; sda_m = 1'b0; wq;
    chk("R10 released after abort", {63'd0, sda_oe}, 64'd0);
    scl_m = 1'b0; wq;
    put_byte(8'h00, ok);
    chk("R10 idle after abort", {63'd0, ok}, 64'd0);
    bus_stop;
    chk("R10 no partial write", {56'd0, ctl_o[23:16]}, {56'd0, 8'h33});
    byte_wr(8'h02, 8'h44, ok);
    byte_rd(8'h02, rd);
    chk("R10 recovery", {56'd0, rd}, {56'd0, 8'h44});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule